// File: doc/BRIEF.md
# Global-Chop Conversion Sequencer

This block sits between the decimation filter of a delta-sigma converter and its output data path. In plain mode it groups modulator ticks into conversion periods of `osrCfg` ticks and forwards the filter value present at the last tick of each period. The output data rate is therefore the modulator rate divided by the oversampling ratio.

When `chopEn` is set, the block drives the polarity switch of the analog front end. The first chopped conversion uses normal polarity, and the polarity reverses after every accepted conversion. Each swap resets the filter and waits a programmable settling time. The block then lets two unsettled conversion periods pass and accepts the third. An accepted value taken with reversed polarity is negated. Each new value is averaged with the previous one, so the front end's own offset cancels. An offset that is already present at the converter's inputs is unaffected, because it reverses together with the signal.

A new result is announced by a one-cycle low pulse on `dataReadyN`. The filter, the modulator and any configuration registers are outside the block.

Top module: `chop_sequencer`

## Requirements
- R1: With `chopEn` clear, each run of `osrCfg` modulator ticks (`osrCfg` >= 2) ends a conversion period. At that last tick, `filtData` becomes the result if `filtValid` is high, and the period produces no result if `filtValid` is low.
- R2: `dataReadyN` goes low for exactly one clock, in the cycle after the modulator tick that produced the result, and `result` holds the new value during that cycle.
- R3: `chopPol` (0 = normal, 1 = reversed) is 0 while `chopEn` is clear and at the start of every chopped run. It inverts after each accepted chopped conversion.
- R4: `filtRst` pulses for one clock at every polarity swap and at every change of `chopEn`. The period count restarts at the same time, and a mode change produces no result.
- R5: After each filter reset in chopped mode, the first two conversion periods are discarded. The third is accepted if `filtValid` is high at its last tick; otherwise the next period is tried.
- R6: After a swap, the block waits 2^`dlySel` modulator ticks before the next period begins. Accepts are therefore 3·`osrCfg` ticks after entering chopped mode and 2^`dlySel` + 3·`osrCfg` ticks after each swap.
- R7: A chopped result equals (s_prev + s_new) >>> 1, where s is the accepted value and is negated when it was taken with `chopPol` = 1. Pairs overlap: each accepted value is used with its predecessor and with its successor.
- R8: The negation and the sum keep a guard bit, so a full-scale negative value taken with reversed polarity gives the correct average without wrapping.
- R9: After `chopEn` is set, no result appears until two settled conversions of opposite polarity have been accepted. Clearing `chopEn` discards the stored value.
- R10: A constant offset that `chopPol` does not reverse cancels: the result equals the floored mean of the two input signals.
- R11: During and after reset, `chopPol` = 0, `filtRst` = 0, `dataReadyN` = 1 and `result` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modTick | input | 1 | One-clock strobe per modulator period |
| osrCfg | input | OSR_W | Ticks per conversion period (>= 2); change only together with `chopEn` |
| dlySel | input | DSEL_W | Settling delay exponent k, delay = 2^k ticks |
| chopEn | input | 1 | Enables chopped operation |
| filtValid | input | 1 | Filter output qualifier |
| filtData | input | DW | Signed filter output |
| chopPol | output | 1 | Polarity switch control, 1 = reversed |
| filtRst | output | 1 | One-clock filter reset pulse |
| result | output | DW | Signed output value |
| dataReadyN | output | 1 | Active-low new-result strobe |

## Verification
The filter stub returns a garbage marker for two periods after every `filtRst`. A sequencer that accepts the wrong period therefore shows an unsettled value or a tick count that differs from R6. A skipped delay shifts that tick count by 2^k, and a swap without negation breaks the offset cancellation that the bench checks against the stub's own input values. A directed run feeds full-scale negative data so that a missing guard bit shows up as a wrapped average. The bench also drops `filtValid`, toggles `chopEn` in the middle of settling and re-enables the block, which exposes a stale stored value that leaks into a new pair.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    ST_PLAIN  = 2'd0,
    ST_SETTLE = 2'd1,
    ST_DELAY  = 2'd2
  } seqState_t;

  // strobes from the sequencer control to the arithmetic path
  typedef struct packed {
    logic plainTake;  // forward the filter value unchanged
    logic chopTake;   // settled chopped value accepted
    logic negate;     // value was taken with reversed polarity
    logic flush;      // drop the stored previous value
  } dpStrobe_t;

  localparam int SETTLE_DISCARD = 2;

endpackage

// File: rtl/chop_ctrl.sv
module chop_ctrl
  import chop_pkg::*;
#(
  parameter int OSR_W  = 8,
  parameter int DSEL_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modTick,
  input  logic [OSR_W-1:0]  osrCfg,
  input  logic [DSEL_W-1:0] dlySel,
  input  logic              chopEn,
  input  logic              filtValid,
  output logic              chopPol,
  output logic              filtRst,
  output dpStrobe_t         strobe
);

  localparam int DLY_W = 1 << DSEL_W;

  seqState_t        state;
  logic [OSR_W-1:0] periodCnt;
  logic [1:0]       settleCnt;
  logic [DLY_W-1:0] dlyCnt;

  logic modeOn, modeChange, lastTick, settled;

  always_comb begin
    modeOn     = (state != ST_PLAIN);
    modeChange = (chopEn != modeOn);
    lastTick   = modTick && (state != ST_DELAY) &&
                 (periodCnt == osrCfg - OSR_W'(1));
    settled    = (settleCnt == 2'(SETTLE_DISCARD));

    strobe           = '0;
    strobe.negate    = chopPol;
    strobe.flush     = modeChange;
    if (!modeChange) begin
      strobe.plainTake = (state == ST_PLAIN)  && lastTick && filtValid;
      strobe.chopTake  = (state == ST_SETTLE) && lastTick && settled && filtValid;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_PLAIN;
      periodCnt <= '0;
      settleCnt <= '0;
      dlyCnt    <= '0;
      chopPol   <= 1'b0;
      filtRst   <= 1'b0;
    end else begin
      filtRst <= 1'b0;
      if (modeChange) begin
        state     <= chopEn ? ST_SETTLE : ST_PLAIN;
        periodCnt <= '0;
        settleCnt <= '0;
        chopPol   <= 1'b0;
        filtRst   <= 1'b1;
      end else begin
        case (state)
          ST_PLAIN: begin
            if (lastTick)     periodCnt <= '0;
            else if (modTick) periodCnt <= periodCnt + OSR_W'(1);
          end
          ST_SETTLE: begin
            if (lastTick) begin
              periodCnt <= '0;
              if (!settled) begin
                settleCnt <= settleCnt + 2'd1;
              end else if (filtValid) begin
                chopPol   <= ~chopPol;
                filtRst   <= 1'b1;
                settleCnt <= '0;
                dlyCnt    <= DLY_W'(1) << dlySel;
                state     <= ST_DELAY;
              end
            end else if (modTick) begin
              periodCnt <= periodCnt + OSR_W'(1);
            end
          end
          ST_DELAY: begin
            if (modTick) begin
              if (dlyCnt == DLY_W'(1)) begin
                state     <= ST_SETTLE;
                periodCnt <= '0;
              end else begin
                dlyCnt <= dlyCnt - DLY_W'(1);
              end
            end
          end
          default: state <= ST_PLAIN;
        endcase
      end
    end
  end

endmodule

// File: rtl/chop_dp.sv
module chop_dp
  import chop_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic signed [DW-1:0] filtData,
  input  dpStrobe_t            strobe,
  output logic signed [DW-1:0] result,
  output logic                 dataReadyN,
  output logic                 guardSpill
);

  localparam int SW = DW + 1;  // one guard bit for negation
  localparam int AW = DW + 2;  // one more for the pair sum

  logic signed [SW-1:0] xExt, sNew, prevS;
  logic signed [AW-1:0] pairSum, pairAvg;
  logic                 havePrev;

  always_comb begin
    xExt    = {filtData[DW-1], filtData};
    sNew    = strobe.negate ? -xExt : xExt;
    pairSum = {sNew[SW-1], sNew} + {prevS[SW-1], prevS};
    pairAvg = pairSum >>> 1;
    guardSpill = (pairAvg[AW-1:DW] != {(AW-DW){pairAvg[DW-1]}});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result     <= '0;
      dataReadyN <= 1'b1;
      prevS      <= '0;
      havePrev   <= 1'b0;
    end else begin
      dataReadyN <= 1'b1;
      if (strobe.plainTake) begin
        result     <= filtData;
        dataReadyN <= 1'b0;
      end
      if (strobe.chopTake) begin
        prevS    <= sNew;
        havePrev <= 1'b1;
        if (havePrev) begin
          result     <= pairAvg[DW-1:0];
          dataReadyN <= 1'b0;
        end
      end
      if (strobe.flush) havePrev <= 1'b0;
    end
  end

endmodule

// File: rtl/chop_sequencer.sv
module chop_sequencer
  import chop_pkg::*;
#(
  parameter int DW     = 16,
  parameter int OSR_W  = 8,
  parameter int DSEL_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 modTick,
  input  logic [OSR_W-1:0]     osrCfg,
  input  logic [DSEL_W-1:0]    dlySel,
  input  logic                 chopEn,
  input  logic                 filtValid,
  input  logic signed [DW-1:0] filtData,
  output logic                 chopPol,
  output logic                 filtRst,
  output logic signed [DW-1:0] result,
  output logic                 dataReadyN
);

  dpStrobe_t strobe;
  logic      guardSpill;

  chop_ctrl #(.OSR_W(OSR_W), .DSEL_W(DSEL_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .modTick   (modTick),
    .osrCfg    (osrCfg),
    .dlySel    (dlySel),
    .chopEn    (chopEn),
    .filtValid (filtValid),
    .chopPol   (chopPol),
    .filtRst   (filtRst),
    .strobe    (strobe)
  );

  chop_dp #(.DW(DW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .filtData   (filtData),
    .strobe     (strobe),
    .result     (result),
    .dataReadyN (dataReadyN),
    .guardSpill (guardSpill)
  );

endmodule

// File: rtl/chop_checker.sv
module chop_checker (
  input logic clk,
  input logic rstN,
  input logic modTick,
  input logic chopEn,
  input logic chopPol,
  input logic filtRst,
  input logic dataReadyN,
  input logic guardSpill
);

  // R2: the ready strobe lasts a single clock
  a_r2_drdy_single: assert property (@(posedge clk) disable iff (!rstN)
    !dataReadyN |=> dataReadyN);

  // R2: a result only follows a modulator tick
  a_r2_drdy_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    !dataReadyN |-> $past(modTick));

  // R4: the polarity never moves without a filter reset
  a_r4_swap_resets: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(chopPol) |-> filtRst);

  // R3: normal polarity whenever chopping was off
  a_r3_normal_when_off: assert property (@(posedge clk) disable iff (!rstN)
    $past(!chopEn) |-> !chopPol);

  // R9: enabling never emits a result right away
  a_r9_quiet_on_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chopEn) |=> dataReadyN);

  // R8: the pair average always fits the output width
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    !guardSpill);

endmodule

bind chop_sequencer chop_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .modTick    (modTick),
  .chopEn     (chopEn),
  .chopPol    (chopPol),
  .filtRst    (filtRst),
  .dataReadyN (dataReadyN),
  .guardSpill (guardSpill)
);

// File: tb/tb_chop_sequencer.sv
module tb_chop_sequencer;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              modTick = 1'b0;
  logic [7:0]        osrCfg = 8'd4;
  logic [3:0]        dlySel = 4'd0;
  logic              chopEn = 1'b0;
  logic              filtValid = 1'b1;
  logic signed [15:0] filtData = '0;
  logic              chopPol, filtRst, dataReadyN;
  logic signed [15:0] result;

  chop_sequencer dut (
    .clk(clk), .rstN(rstN), .modTick(modTick), .osrCfg(osrCfg),
    .dlySel(dlySel), .chopEn(chopEn), .filtValid(filtValid),
    .filtData(filtData), .chopPol(chopPol), .filtRst(filtRst),
    .result(result), .dataReadyN(dataReadyN)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // stub and model state
  int  vin = 0, ofs = 0, ticksSince = 0, plainCnt = 0;
  int  dataVin = 0, lastTickVin = 0, lastTickSince = 0, lastTickData = 0;
  bit  dataGood = 0, lastTickGood = 0, lastTickPol = 0, lastTickValid = 0;
  bit  forceMin = 0, plainActive = 0, pendPlain = 0, prevLow = 0;
  int  sessRst = 0, chopOuts = 0;
  bit  haveS = 0, prevP = 0;
  int  prevX = 0, prevVin = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int avgExp(int x1, bit p1, int x2, bit p2);
    int s1 = p1 ? -x1 : x1;
    int s2 = p2 ? -x2 : x2;
    return (s1 + s2) >>> 1;
  endfunction

  function automatic int newVin();
    return int'($urandom_range(0, 16000)) - 8000;
  endfunction

  // tick source, driven away from the clock edge
  always begin
    @(posedge clk); #2;
    modTick = ($urandom_range(0, 1) == 1);
  end

  // filter stub: two unsettled periods after each reset
  always @(posedge clk) begin
    int x;
    bit good;
    if (rstN) begin
      if (modTick) begin
        lastTickData  = filtData;
        lastTickPol   = chopPol;
        lastTickGood  = dataGood;
        lastTickVin   = dataVin;
        lastTickValid = filtValid;
      end
      if (filtRst) begin
        ticksSince = modTick ? 1 : 0;
        vin = newVin();
      end else if (modTick) begin
        ticksSince++;
        if (!chopEn) vin = newVin();
      end
      if (modTick) lastTickSince = ticksSince;
      if (plainActive && !chopEn) begin
        if (filtRst) plainCnt = modTick ? 1 : 0;
        else if (modTick) plainCnt++;
        if (plainCnt == int'(osrCfg)) begin
          pendPlain = 1;
          plainCnt = 0;
        end
      end
      good = (ticksSince >= 2 * int'(osrCfg));
      x = (chopPol ? -vin : vin) + ofs;
      dataVin  = vin;
      dataGood = good;
      if (forceMin) filtData <= 16'sh8000;
      else if (!good) filtData <= 16'sh7A5A;
      else filtData <= 16'(x);
    end
  end

  // monitor, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (!dataReadyN) begin
        chk(!prevLow, "R2 single-cycle ready", 0, 1);
      end
      prevLow = !dataReadyN;
      if (filtRst) begin
        if (sessRst == 0) begin
          chk(chopPol == 1'b0, "R3 normal polarity at mode change", chopPol, 0);
          chk(dataReadyN == 1'b1, "R4 no result at mode change", dataReadyN, 1);
          haveS = 0;
          sessRst = 1;
          if (!chopEn) plainActive = 1;
          pendPlain = 0;
        end else begin
          chk(lastTickGood, "R5 settled value accepted", lastTickGood, 1);
          chk(lastTickSince == ((sessRst == 1) ? 3 * int'(osrCfg)
                                : (1 << dlySel) + 3 * int'(osrCfg)),
              "R6 ticks to accept", lastTickSince,
              (sessRst == 1) ? 3 * int'(osrCfg) : (1 << dlySel) + 3 * int'(osrCfg));
          chk(chopPol == !lastTickPol, "R3 polarity toggles", chopPol, !lastTickPol);
          if (haveS) begin
            chk(dataReadyN == 1'b0, "R7 pair result ready", dataReadyN, 0);
            chk(int'(result) == avgExp(prevX, prevP, lastTickData, lastTickPol),
                "R7 pair average", int'(result),
                avgExp(prevX, prevP, lastTickData, lastTickPol));
            if (forceMin)
              chk(int'(result) == 0, "R8 full-scale guard", int'(result), 0);
            else
              chk(int'(result) == ((prevVin + lastTickVin) >>> 1),
                  "R10 offset cancelled", int'(result), (prevVin + lastTickVin) >>> 1);
            chopOuts++;
          end else begin
            chk(dataReadyN == 1'b1, "R9 no result before pair", dataReadyN, 1);
          end
          prevX = lastTickData; prevP = lastTickPol; prevVin = lastTickVin;
          haveS = 1;
          sessRst++;
        end
      end else if (chopEn && sessRst > 0) begin
        if (!dataReadyN) chk(0, "R7 result only at accept", 0, 1);
      end else if (plainActive) begin
        if ((dataReadyN == 1'b0) != (pendPlain && lastTickValid))
          chk(0, "R1 plain result timing", !dataReadyN, pendPlain && lastTickValid);
        if (!dataReadyN)
          chk(int'(result) == lastTickData, "R1 plain value", int'(result), lastTickData);
        pendPlain = 0;
      end
    end
  end

  task automatic setMode(bit en, int osr, int k, bit fm);
    @(posedge clk); #2;
    if (en) begin
      osrCfg = 8'(osr);
      dlySel = 4'(k);
      forceMin = fm;
      ofs = fm ? 0 : int'($urandom_range(0, 4000)) - 2000;
      plainActive = 0;
    end
    sessRst = 0;
    chopEn = en;
    repeat (3) @(posedge clk);
    #2;
    chk(sessRst >= 1, "R4 reset on mode change", sessRst, 1);
  endtask

  task automatic runChop(int osr, int k, int nOut, bit fm);
    int target;
    setMode(1, osr, k, fm);
    target = chopOuts + nOut;
    while (chopOuts < target) @(posedge clk);
    setMode(0, osr, k, 0);
    repeat (40) @(posedge clk);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    #2;
    chk(chopPol == 0 && filtRst == 0, "R11 reset outputs", {chopPol, filtRst}, 0);
    chk(dataReadyN == 1 && result == 0, "R11 reset result", int'(result), 0);
    rstN = 1;
    plainActive = 1;
    repeat (200) @(posedge clk);
    #2 filtValid = 0;                  // R1: dropped periods
    repeat (30) @(posedge clk);
    #2 filtValid = 1;
    repeat (100) @(posedge clk);
    runChop(2, 0, 6, 0);               // shortest period and delay
    runChop(4, 3, 8, 0);
    setMode(1, 5, 2, 0);               // R9: abort during settling
    repeat (12) @(posedge clk);
    setMode(0, 5, 2, 0);
    repeat (60) @(posedge clk);
    runChop(3, 6, 4, 0);               // long delay
    runChop(4, 1, 6, 1);               // R8: full-scale negative data
    for (int i = 0; i < 6; i++) begin
      runChop(int'($urandom_range(2, 8)), int'($urandom_range(0, 5)), 5, 0);
    end
    repeat (100) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule